// File: doc/BRIEF.md
# Byte-Lane Steering Unit with Misaligned Word Splitting

This block connects an internal requester to a 16-bit memory bus. The bus is built from two 8-bit banks that share one address. Each request is a byte or word read or write at any byte address in a 20-bit space. The block drives the two byte enables: `bus_bhe_n`, active low, for the upper lane, and `bus_addr[0]`, low for the lower lane. It places write bytes on the lane that serves their address and collects read bytes back into little-endian order. The low byte of a word sits at its own address and the high byte at the next address.

A word at an even address takes one bus access. A word at an odd address becomes two accesses in a fixed order. The requester does not see the split: it gets one completion pulse once both halves are done. Instruction fetches are always whole aligned words, so they never split. Bus-cycle timing is left to an external sequencer. That sequencer answers each held `bus_req` with a one-cycle `bus_ack`, and `bus_rdata` is valid during that cycle.

Top module: `lane_steer_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_req` is 0 and `rsp_done` is 0.
- R2: A byte at an even address uses one access with `bus_addr[0]`=0 and `bus_bhe_n`=1. The write byte goes on lane 7..0 with lane 15..8 driven to zero. The read result is `{8'h00, bus_rdata[7:0]}`.
- R3: A byte at an odd address uses one access with `bus_addr[0]`=1 and `bus_bhe_n`=0. The write byte goes on lane 15..8 with lane 7..0 driven to zero. The read result is `{8'h00, bus_rdata[15:8]}`. An access with `bus_addr[0]`=1 never has `bus_bhe_n`=1.
- R4: A word at an even address uses one access with `bus_bhe_n`=0 and `bus_addr[0]`=0. Write data goes out unchanged, and the read result is `bus_rdata` unchanged.
- R5: A word data access at an odd address A uses two accesses in order. The first is at A with `bus_bhe_n`=0 and carries the low byte on lane 15..8. The second is at A+1 with `bus_bhe_n`=1 and carries the high byte on lane 7..0. On writes, the lane not in use is zero.
- R6: The second address of a split access wraps from FFFFFh to 00000h.
- R7: Each request gives exactly one `rsp_done` pulse, one cycle long. It comes in the cycle after the final `bus_ack`. For a split read, `rsp_rdata` is `{high byte, low byte}`.
- R8: A fetch (`req_fetch`=1) is one read at the address with bit 0 cleared, with both enables active, and returns `bus_rdata` unchanged. `req_write` and `req_word` have no effect on a fetch.
- R9: While a request is in flight, `req_ready` is 0. `bus_addr`, `bus_bhe_n`, `bus_we` and `bus_wdata` hold steady until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | 20 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_fetch | input | 1 | Instruction fetch of an aligned word |
| req_wdata | input | 16 | Write data; a byte uses bits 7..0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Assembled read data |
| bus_req | output | 1 | Bus access requested |
| bus_addr | output | 20 | Bus address; bit 0 is the lower-lane enable (active low) |
| bus_bhe_n | output | 1 | Upper-lane enable, active low |
| bus_we | output | 1 | Bus write |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both lanes |
| bus_ack | input | 1 | Access complete; read data valid |

## Verification
The bench covers each mode in turn: even and odd bytes, even and odd words, read and write, and fetch. These show whether lane choice follows address bit 0 and whether the split happens only for odd data words. A write sets the two bytes of a word to different values, so a swapped or missing byte is visible. On split reads, the bus returns different filler in the lane not in use, so taking the wrong lane is also visible. A split at FFFFFh checks the address wrap. A fetch at an odd address with write set checks that the fetch is aligned and the write flag ignored. Ack delays from zero to three cycles test that outputs hold and that the completion pulse comes only once.

// File: rtl/lane_pkg.sv
// Package: shared sizes and encodings for the byte-lane steering unit.
// Assumes a bus of two equal lanes that share one address.
package lane_pkg;
    localparam int ADDR_W = 20;
    localparam int LANE_W = 8;

    // Where a captured read byte or word lands in the result.
    typedef enum logic [1:0] {
        DEST_FULL = 2'd0,
        DEST_LO   = 2'd1,
        DEST_HI   = 2'd2
    } dest_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT1 = 2'd1,
        ST_BEAT2 = 2'd2
    } seq_st_e;
endpackage

// File: rtl/lane_plan.sv
// Module: lane_plan
// Works out, from the held request and the current beat, the bus
// address, upper-lane enable, write lanes and where read data lands.
// Purely combinational. Assumes a two-lane bus; address bit 0 is the
// lower-lane enable.
module lane_plan
    import lane_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LANE_W
) (
    input  logic [AW-1:0]   req_addr,
    input  logic            req_wr,
    input  logic            req_word,
    input  logic            req_fetch,
    input  logic [2*LW-1:0] req_wdata,
    input  logic            phase2,
    output logic [AW-1:0]   beat_addr,
    output logic            beat_bhe_n,
    output logic            beat_we,
    output logic [2*LW-1:0] beat_wdata,
    output logic            beat_split,
    output logic            beat_lane_hi,
    output dest_e           beat_dest
);
    localparam int DW = 2 * LW;

    // Pick the enables, lanes and destination for the current beat.
    always_comb begin
        beat_split   = req_word & req_addr[0] & ~req_fetch;
        beat_addr    = req_addr;
        beat_bhe_n   = 1'b1;
        beat_we      = req_wr & ~req_fetch;
        beat_wdata   = '0;
        beat_lane_hi = 1'b0;
        beat_dest    = DEST_LO;
        if (req_fetch) begin
            beat_addr  = {req_addr[AW-1:1], 1'b0};
            beat_bhe_n = 1'b0;
            beat_dest  = DEST_FULL;
        end else if (phase2) begin
            beat_addr             = req_addr + AW'(1);
            beat_wdata[LW-1:0]    = req_wdata[DW-1:LW];
            beat_dest             = DEST_HI;
        end else if (req_addr[0]) begin
            beat_bhe_n            = 1'b0;
            beat_wdata[DW-1:LW]   = req_wdata[LW-1:0];
            beat_lane_hi          = 1'b1;
        end else if (req_word) begin
            beat_bhe_n = 1'b0;
            beat_wdata = req_wdata;
            beat_dest  = DEST_FULL;
        end else begin
            beat_wdata[LW-1:0] = req_wdata[LW-1:0];
        end
    end
endmodule

// File: rtl/lane_gather.sv
// Module: lane_gather
// Holds the read result and fills it in from the chosen bus lane on
// each read ack. Assumes the low half of a split is captured first.
module lane_gather
    import lane_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            lane_hi,
    input  dest_e           dest,
    input  logic [2*LW-1:0] bus_rdata,
    output logic [2*LW-1:0] rdata_q
);
    localparam int DW = 2 * LW;

    logic [LW-1:0] pick;

    // Select the byte from the lane that served this beat.
    always_comb pick = lane_hi ? bus_rdata[DW-1:LW] : bus_rdata[LW-1:0];

    // Place captured data into the result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            case (dest)
                DEST_FULL: rdata_q <= bus_rdata;
                DEST_HI:   rdata_q[DW-1:LW] <= pick;
                default:   rdata_q <= {{LW{1'b0}}, pick};
            endcase
        end
    end
endmodule

// File: rtl/lane_seq.sv
// Module: lane_seq
// Steps a request through one or two bus beats and raises a single
// done pulse after the last ack. Assumes bus_ack lasts one cycle.
module lane_seq
    import lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_ack,
    input  logic split,
    output logic load,
    output logic busy,
    output logic phase2,
    output logic done
);
    seq_st_e state;

    // Decode the handshake outputs from the state.
    always_comb begin
        load   = (state == ST_IDLE) && req_valid;
        busy   = (state != ST_IDLE);
        phase2 = (state == ST_BEAT2);
    end

    // Advance the beat state and form the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE:  if (req_valid) state <= ST_BEAT1;
                ST_BEAT1: if (bus_ack) begin
                    if (split) begin
                        state <= ST_BEAT2;
                    end else begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_BEAT2: if (bus_ack) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    split_second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT1 && bus_ack && split) |=> (phase2 && !done));
endmodule

// File: rtl/lane_steer_unit.sv
// Module: lane_steer_unit (top)
// Takes byte/word requests at any byte address, steers them onto a
// two-lane bus, splits odd data words into two beats and returns one
// completion. Assumes an external sequencer acks each held bus_req.
module lane_steer_unit
    import lane_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LANE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic            req_word,
    input  logic            req_fetch,
    input  logic [2*LW-1:0] req_wdata,
    output logic            rsp_done,
    output logic [2*LW-1:0] rsp_rdata,
    output logic            bus_req,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_bhe_n,
    output logic            bus_we,
    output logic [2*LW-1:0] bus_wdata,
    input  logic [2*LW-1:0] bus_rdata,
    input  logic            bus_ack
);
    localparam int DW = 2 * LW;

    logic [AW-1:0] addr_q;
    logic          wr_q, word_q, fetch_q;
    logic [DW-1:0] wdata_q;
    logic          load, busy, phase2, split, lane_hi;
    dest_e         dest;

    // Hold the accepted request for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            word_q  <= 1'b0;
            fetch_q <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            word_q  <= req_word;
            fetch_q <= req_fetch;
            wdata_q <= req_wdata;
        end
    end

    lane_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_ack(bus_ack),
        .split(split), .load(load), .busy(busy), .phase2(phase2), .done(rsp_done)
    );

    lane_plan #(.AW(AW), .LW(LW)) u_plan (
        .req_addr(addr_q), .req_wr(wr_q), .req_word(word_q), .req_fetch(fetch_q),
        .req_wdata(wdata_q), .phase2(phase2), .beat_addr(bus_addr),
        .beat_bhe_n(bus_bhe_n), .beat_we(bus_we), .beat_wdata(bus_wdata),
        .beat_split(split), .beat_lane_hi(lane_hi), .beat_dest(dest)
    );

    lane_gather #(.LW(LW)) u_gather (
        .clk(clk), .rst_n(rst_n), .capture(bus_ack && busy && !bus_we),
        .lane_hi(lane_hi), .dest(dest), .bus_rdata(bus_rdata), .rdata_q(rsp_rdata)
    );

    // Present handshake status to both sides.
    always_comb begin
        req_ready = !busy;
        bus_req   = busy;
    end

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_bhe_n)
                                   && $stable(bus_we) && $stable(bus_wdata)));
    // R9
    ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && bus_req));
    // R3
    enable_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr[0]) |-> !bus_bhe_n);
    // R6
    split_next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase2) |-> (bus_addr == AW'($past(bus_addr) + AW'(1)) && bus_bhe_n));
    // R8
    fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && fetch_q) |-> (!bus_addr[0] && !bus_we && !bus_bhe_n));
endmodule

// File: tb/lane_steer_unit_bench.sv
// Bench: scoreboard. The driver task pushes expected bus beats and
// responses; a bus responder and a response monitor pop and compare.
module lane_steer_unit_bench;
    typedef struct {
        logic [19:0] addr;
        logic        bhe_n;
        logic        we;
        logic [15:0] wdata;
        logic [15:0] rdata;
        int          wait_n;
        string       tag;
    } beat_t;

    typedef struct {
        logic        chk_data;
        logic [15:0] rdata;
        string       tag;
    } rsp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        bus_req, bus_bhe_n, bus_we;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit ended = 0;
    beat_t beat_q[$];
    rsp_t  rsp_q[$];

    always #4 clk = ~clk;

    lane_steer_unit u_lane_steer_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
        .req_fetch(req_fetch), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_bhe_n(bus_bhe_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act,
                         input logic [39:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_beat(input logic [19:0] a, input logic bh, input logic we,
                             input logic [15:0] wd, input logic [15:0] rd,
                             input int w, input string tag);
        beat_t b;
        b.addr = a; b.bhe_n = bh; b.we = we; b.wdata = wd;
        b.rdata = rd; b.wait_n = w; b.tag = tag;
        beat_q.push_back(b);
    endtask

    // Driver: derive expected beats and response from the requirements.
    task automatic issue(input logic [19:0] a, input logic wr, input logic wd,
                         input logic fe, input logic [15:0] data,
                         input logic [15:0] rd1, input logic [15:0] rd2,
                         input int w, input string tag);
        rsp_t r;
        r.tag = tag;
        r.chk_data = fe || !wr;
        if (fe) begin
            push_beat({a[19:1], 1'b0}, 1'b0, 1'b0, 16'h0, rd1, w, tag);
            r.rdata = rd1;
        end else if (wd && a[0]) begin
            push_beat(a, 1'b0, wr, {data[7:0], 8'h00}, rd1, w, tag);
            push_beat(a + 20'd1, 1'b1, wr, {8'h00, data[15:8]}, rd2, w, tag);
            r.rdata = {rd2[7:0], rd1[15:8]};
        end else if (wd) begin
            push_beat(a, 1'b0, wr, data, rd1, w, tag);
            r.rdata = rd1;
        end else if (a[0]) begin
            push_beat(a, 1'b0, wr, {data[7:0], 8'h00}, rd1, w, tag);
            r.rdata = {8'h00, rd1[15:8]};
        end else begin
            push_beat(a, 1'b1, wr, {8'h00, data[7:0]}, rd1, w, tag);
            r.rdata = {8'h00, rd1[7:0]};
        end
        rsp_q.push_back(r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd;
        req_fetch = fe; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_q.size() != 0) @(negedge clk);
    endtask

    // Bus responder: compare each beat against the queue, then ack.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                beat_t b;
                if (beat_q.size() == 0) begin
                    check(0, "R5 unexpected bus beat", {20'h0, bus_addr}, 40'h0);
                end else begin
                    b = beat_q.pop_front();
                    check(bus_addr == b.addr, {b.tag, " addr"}, {20'h0, bus_addr}, {20'h0, b.addr});
                    check(bus_bhe_n == b.bhe_n, {b.tag, " bhe_n"}, {39'h0, bus_bhe_n}, {39'h0, b.bhe_n});
                    check(bus_we == b.we, {b.tag, " we"}, {39'h0, bus_we}, {39'h0, b.we});
                    if (b.we)
                        check(bus_wdata == b.wdata, {b.tag, " wdata"}, {24'h0, bus_wdata}, {24'h0, b.wdata});
                    check(!req_ready, "R9 ready low while busy", {39'h0, req_ready}, 40'h0);
                    repeat (b.wait_n) @(negedge clk);
                    check(bus_req && bus_addr == b.addr && bus_bhe_n == b.bhe_n,
                          "R9 held until ack", {20'h0, bus_addr}, {20'h0, b.addr});
                    bus_rdata = b.rdata;
                    bus_ack = 1'b1;
                    @(negedge clk);
                    bus_ack = 1'b0;
                    bus_rdata = 16'hxxxx;
                end
            end
        end
    end

    // Response monitor: one done pulse per request, with the right data.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                rsp_t r;
                if (rsp_q.size() == 0) begin
                    check(0, "R7 extra done pulse", 40'h1, 40'h0);
                end else begin
                    r = rsp_q.pop_front();
                    check(beat_q.size() == 0, {r.tag, " R7 done before last beat"},
                          40'(beat_q.size()), 40'h0);
                    if (r.chk_data)
                        check(rsp_rdata == r.rdata, {r.tag, " rdata"}, {24'h0, rsp_rdata}, {24'h0, r.rdata});
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", {39'h0, req_ready}, 40'h1);
        check(bus_req == 1'b0, "R1 bus_req", {39'h0, bus_req}, 40'h0);
        check(rsp_done == 1'b0, "R1 rsp_done", {39'h0, rsp_done}, 40'h0);

        issue(20'h00124, 0, 0, 0, 16'h0000, 16'hAB55, 16'h0, 0, "R2 even byte rd");
        issue(20'h00200, 1, 0, 0, 16'hF0C3, 16'h0, 16'h0, 1, "R2 even byte wr");
        issue(20'h00125, 0, 0, 0, 16'h0000, 16'h7E11, 16'h0, 2, "R3 odd byte rd");
        issue(20'h00201, 1, 0, 0, 16'h12C3, 16'h0, 16'h0, 0, "R3 odd byte wr");
        issue(20'h00340, 0, 1, 0, 16'h0000, 16'hBEEF, 16'h0, 3, "R4 even word rd");
        issue(20'h00342, 1, 1, 0, 16'h1234, 16'h0, 16'h0, 1, "R4 even word wr");
        issue(20'h00345, 0, 1, 0, 16'h0000, 16'h34AA, 16'h5512, 0, "R5 R7 odd word rd");
        issue(20'h00347, 1, 1, 0, 16'hA55A, 16'h0, 16'h0, 2, "R5 odd word wr");
        issue(20'h3FFF9, 0, 1, 0, 16'h0000, 16'h9966, 16'h6677, 3, "R5 R7 odd word rd slow");
        issue(20'hFFFFF, 0, 1, 0, 16'h0000, 16'hCD00, 16'h00EF, 1, "R6 wrap rd");
        issue(20'hFFFFF, 1, 1, 0, 16'h5AA5, 16'h0, 16'h0, 0, "R6 wrap wr");
        issue(20'h01235, 1, 1, 1, 16'hDEAD, 16'h8086, 16'h0, 1, "R8 odd fetch");
        issue(20'h01000, 0, 0, 1, 16'h0000, 16'h4321, 16'h0, 0, "R8 even fetch");

        repeat (10) @(negedge clk);
        // R7: every expected response seen exactly once
        check(rsp_q.size() == 0 && beat_q.size() == 0, "R7 queues drained",
              40'(rsp_q.size() + beat_q.size()), 40'h0);
        check(req_ready && !bus_req && !rsp_done, "R9 idle at end",
              {37'h0, req_ready, bus_req, rsp_done}, 40'h4);
        finish_run();
    end
endmodule